// File: doc/BRIEF.md
# Line-Splitting DMA Request Sequencer

This block takes one DMA transfer at a time, described by a start byte address, a byte count and a direction (load or store). It cuts the transfer into segments that never straddle a cache-line boundary. It hands those segments, one at a time, to a line-based memory controller downstream. A segment that starts in the middle of a line stops at the end of that line, and every later segment starts on a line boundary.

Store data is read from an internal byte-wide staging buffer, which the requester fills beforehand through a simple byte port. Load data returned by the controller is written back into the same buffer. The block issues the next segment only after the current one has been answered: an acknowledge for stores, a data beat for loads. When the whole byte count has been moved, it pulses a completion output and becomes idle again.

Top module: `dma_line_seq`

## Requirements
- R1: When idle, a request with type code 0 (load) or 1 (store) and a length from 1 to MAX_LEN raises `req_ok_o` in the same cycle, and `busy_o` is high from the next cycle on.
- R2: While busy, any request raises `req_full_o` in the same cycle, keeps `req_ok_o` low, is not queued, and leaves the running transfer unchanged.
- R3: When idle, a request with a type code other than 0 or 1, or with a length of 0 or above MAX_LEN, raises `req_unsup_o`, starts nothing and leaves `busy_o` low.
- R4: The first segment has the start address. Its length is min(length, LINE_BYTES − offset), where offset = start address mod LINE_BYTES.
- R5: Each later segment has address start + bytes already completed, which is a multiple of LINE_BYTES. Its length is min(bytes remaining, LINE_BYTES).
- R6: A segment presents its byte address, its line address (the byte address with the low log2(LINE_BYTES) bits cleared), the direction (`seg_write_o` 1 for store) and its length. All of these stay stable while `seg_valid_o` is high and `seg_ready_i` is low.
- R7: Only one segment is in flight. After the handshake `seg_valid_o` stays low until the matching response arrives.
- R8: For a store segment, byte lane j of `seg_data_o` (bits 8j+7..8j) carries buffer byte completed + j − offset for lanes offset ≤ j < offset + length. Here offset is the start offset for the first segment and 0 for later ones. All other lanes are 0.
- R9: For a load segment, the data beat's lanes offset ≤ j < offset + length (offset as in R8) are written to buffer byte completed + j − offset.
- R10: The response that brings the completed count up to the length makes `done_o` high for exactly the next cycle, with `busy_o` low in that cycle.
- R11: A data beat during a store transfer, an acknowledge during a load transfer, or any response while no segment is awaiting a reply raises `proto_err_o` in the same cycle and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request strobe |
| req_type_i | input | 2 | Request type: 0 load, 1 store, others unsupported |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Transfer length in bytes |
| req_ok_o | output | 1 | Request accepted this cycle |
| req_full_o | output | 1 | Request refused, transfer already running |
| req_unsup_o | output | 1 | Request refused, bad type or length |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| buf_we_i | input | 1 | Staging buffer byte write enable |
| buf_addr_i | input | IDX_W | Staging buffer byte index |
| buf_wdata_i | input | 8 | Staging buffer write byte |
| buf_rdata_o | output | 8 | Staging buffer read byte at buf_addr_i |
| seg_valid_o | output | 1 | Segment request valid |
| seg_ready_i | input | 1 | Controller accepts segment |
| seg_addr_o | output | ADDR_W | Segment byte address |
| seg_line_o | output | ADDR_W | Segment line address |
| seg_write_o | output | 1 | Segment direction, 1 for store |
| seg_len_o | output | SEG_W | Segment length in bytes |
| seg_data_o | output | 8*LINE_BYTES | Store data placed in line lanes |
| rsp_ack_i | input | 1 | Store acknowledge pulse |
| rsp_dvalid_i | input | 1 | Load data pulse |
| rsp_data_i | input | 8*LINE_BYTES | Returned line data |
| proto_err_o | output | 1 | Unexpected response seen |

## Verification
The assertions assume that the controller drops `seg_ready_i` or ignores it outside a valid segment, and that the requester only writes the staging buffer through the byte port while the block is idle. The bench keeps to both: it fills and reads the buffer only between transfers, and it asserts ready only while `seg_valid_o` is high. Requests are driven only with lengths the block accepts, except in the scenarios that test refusal. Responses are produced only after a handshake, except in the protocol-error scenario. That scenario injects stray pulses and then checks that the transfer still completes normally.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} seq_state_e;
  localparam logic [1:0] REQ_LOAD  = 2'd0;
  localparam logic [1:0] REQ_STORE = 2'd1;
endpackage

// File: rtl/dma_seg_calc.sv
module dma_seg_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 9,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SEG_W     = $clog2(LINE_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  remain_i,
  input  logic              first_i,
  output logic [OFF_W-1:0]  off_o,
  output logic [SEG_W-1:0]  len_o
);
  logic [SEG_W-1:0] room;

  always_comb begin
    off_o = first_i ? addr_i[OFF_W-1:0] : '0;
    room  = SEG_W'(LINE_BYTES) - SEG_W'(off_o);
    if (32'(remain_i) < 32'(room)) len_o = SEG_W'(remain_i);
    else                           len_o = room;
  end
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int DEPTH      = 256,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 9,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SEG_W     = $clog2(LINE_BYTES + 1),
  localparam int DW        = LINE_BYTES * 8
) (
  input  logic             clk_i,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_addr_i,
  input  logic [7:0]       host_wdata_i,
  output logic [7:0]       host_rdata_o,
  input  logic [LEN_W-1:0] base_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SEG_W-1:0] len_i,
  output logic [DW-1:0]    line_o,
  input  logic             line_we_i,
  input  logic [DW-1:0]    line_i
);
  logic [7:0]            mem [DEPTH];
  logic [LINE_BYTES-1:0] lane_en;
  logic [IDX_W-1:0]      lane_idx [LINE_BYTES];

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    logic [LEN_W-1:0] pos;
    assign pos         = base_i + LEN_W'(g) - LEN_W'(off_i);
    assign lane_idx[g] = IDX_W'(pos);
    assign lane_en[g]  = (32'(g) >= 32'(off_i)) && (32'(g) < 32'(off_i) + 32'(len_i));
    assign line_o[g*8 +: 8] = lane_en[g] ? mem[lane_idx[g]] : 8'h00;
  end

  assign host_rdata_o = mem[host_addr_i];

  always_ff @(posedge clk_i) begin
    if (host_we_i) mem[host_addr_i] <= host_wdata_i;
    if (line_we_i) begin
      for (int j = 0; j < LINE_BYTES; j++) begin
        if (lane_en[j]) mem[lane_idx[j]] <= line_i[j*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SEG_W     = $clog2(LINE_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_type_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              req_ok_o,
  output logic              req_full_o,
  output logic              req_unsup_o,
  output logic [ADDR_W-1:0] calc_addr_o,
  output logic [LEN_W-1:0]  calc_remain_o,
  output logic              calc_first_o,
  input  logic [OFF_W-1:0]  calc_off_i,
  input  logic [SEG_W-1:0]  calc_len_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [ADDR_W-1:0] seg_addr_o,
  output logic              seg_write_o,
  output logic [SEG_W-1:0]  seg_len_o,
  output logic [OFF_W-1:0]  seg_off_o,
  output logic [LEN_W-1:0]  cmpl_o,
  input  logic              rsp_ack_i,
  input  logic              rsp_dvalid_i,
  output logic              capture_o,
  output logic              proto_err_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] start_q, addr_q;
  logic [LEN_W-1:0]  total_q, issued_q, cmpl_q;
  logic              wr_q, done_q;
  logic [OFF_W-1:0]  off_q;
  logic [SEG_W-1:0]  len_q;
  logic              type_ok, len_ok, waiting, rsp_take;

  assign busy_o      = (state_q != ST_IDLE);
  assign type_ok     = (req_type_i == REQ_LOAD) || (req_type_i == REQ_STORE);
  assign len_ok      = (req_len_i != '0) && (32'(req_len_i) <= MAX_LEN);
  assign req_full_o  = req_valid_i && busy_o;
  assign req_ok_o    = req_valid_i && !busy_o && type_ok && len_ok;
  assign req_unsup_o = req_valid_i && !busy_o && !(type_ok && len_ok);

  assign waiting     = (state_q == ST_WAIT);
  assign rsp_take    = waiting && (wr_q ? rsp_ack_i : rsp_dvalid_i);
  assign capture_o   = waiting && !wr_q && rsp_dvalid_i;
  assign proto_err_o = (rsp_ack_i && !(waiting && wr_q)) ||
                       (rsp_dvalid_i && !(waiting && !wr_q));

  // idle: size the first segment from the request; busy: size the next one
  assign calc_addr_o   = busy_o ? start_q + ADDR_W'(issued_q) : req_addr_i;
  assign calc_remain_o = busy_o ? total_q - issued_q : req_len_i;
  assign calc_first_o  = !busy_o;

  assign seg_valid_o = (state_q == ST_SEND);
  assign seg_addr_o  = addr_q;
  assign seg_write_o = wr_q;
  assign seg_len_o   = len_q;
  assign seg_off_o   = off_q;
  assign cmpl_o      = cmpl_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      start_q  <= '0;
      addr_q   <= '0;
      total_q  <= '0;
      issued_q <= '0;
      cmpl_q   <= '0;
      wr_q     <= 1'b0;
      off_q    <= '0;
      len_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_ok_o) begin
          start_q  <= req_addr_i;
          addr_q   <= req_addr_i;
          total_q  <= req_len_i;
          wr_q     <= (req_type_i == REQ_STORE);
          off_q    <= calc_off_i;
          len_q    <= calc_len_i;
          issued_q <= LEN_W'(calc_len_i);
          cmpl_q   <= '0;
          state_q  <= ST_SEND;
        end
        ST_SEND: if (seg_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          cmpl_q <= issued_q;
          if (issued_q == total_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            addr_q   <= calc_addr_o;
            off_q    <= calc_off_i;
            len_q    <= calc_len_i;
            issued_q <= issued_q + LEN_W'(calc_len_i);
            state_q  <= ST_SEND;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int IDX_W     = $clog2(MAX_LEN),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SEG_W     = $clog2(LINE_BYTES + 1),
  localparam int DW        = LINE_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_type_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              req_ok_o,
  output logic              req_full_o,
  output logic              req_unsup_o,
  output logic              busy_o,
  output logic              done_o,
  input  logic              buf_we_i,
  input  logic [IDX_W-1:0]  buf_addr_i,
  input  logic [7:0]        buf_wdata_i,
  output logic [7:0]        buf_rdata_o,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [ADDR_W-1:0] seg_addr_o,
  output logic [ADDR_W-1:0] seg_line_o,
  output logic              seg_write_o,
  output logic [SEG_W-1:0]  seg_len_o,
  output logic [DW-1:0]     seg_data_o,
  input  logic              rsp_ack_i,
  input  logic              rsp_dvalid_i,
  input  logic [DW-1:0]     rsp_data_i,
  output logic              proto_err_o
);
  logic [ADDR_W-1:0] calc_addr;
  logic [LEN_W-1:0]  calc_remain, cmpl_bytes;
  logic              calc_first, capture;
  logic [OFF_W-1:0]  calc_off, seg_off;
  logic [SEG_W-1:0]  calc_len;

  dma_seq_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_type_i, .req_addr_i, .req_len_i,
    .req_ok_o, .req_full_o, .req_unsup_o,
    .calc_addr_o(calc_addr), .calc_remain_o(calc_remain), .calc_first_o(calc_first),
    .calc_off_i(calc_off), .calc_len_i(calc_len),
    .seg_valid_o, .seg_ready_i, .seg_addr_o, .seg_write_o, .seg_len_o,
    .seg_off_o(seg_off), .cmpl_o(cmpl_bytes),
    .rsp_ack_i, .rsp_dvalid_i, .capture_o(capture), .proto_err_o, .busy_o, .done_o
  );

  dma_seg_calc #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)) u_calc (
    .addr_i(calc_addr), .remain_i(calc_remain), .first_i(calc_first),
    .off_o(calc_off), .len_o(calc_len)
  );

  dma_stage_buf #(.DEPTH(MAX_LEN), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)) u_buf (
    .clk_i,
    .host_we_i(buf_we_i), .host_addr_i(buf_addr_i), .host_wdata_i(buf_wdata_i),
    .host_rdata_o(buf_rdata_o),
    .base_i(cmpl_bytes), .off_i(seg_off), .len_i(seg_len_o),
    .line_o(seg_data_o), .line_we_i(capture), .line_i(rsp_data_i)
  );

  assign seg_line_o = seg_addr_o & ~ADDR_W'(LINE_BYTES - 1);
endmodule

// File: rtl/dma_line_seq_chk.sv
module dma_line_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SEG_W     = $clog2(LINE_BYTES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              seg_valid_o,
  input logic              seg_ready_i,
  input logic [ADDR_W-1:0] seg_addr_o,
  input logic              seg_write_o,
  input logic [SEG_W-1:0]  seg_len_o,
  input logic              busy_o,
  input logic              req_ok_o,
  input logic              done_o,
  input logic [LEN_W-1:0]  cmpl_bytes
);
  a_r4_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> (seg_len_o != '0) &&
      (32'(seg_addr_o[OFF_W-1:0]) + 32'(seg_len_o) <= LINE_BYTES));

  a_r5_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && (cmpl_bytes != '0) |-> (seg_addr_o[OFF_W-1:0] == '0));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_addr_o) &&
      $stable(seg_len_o) && $stable(seg_write_o));

  a_r7_one_inflight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && seg_ready_i |=> !seg_valid_o);

  a_r2_busy_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ok_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o ##1 !done_o);
endmodule

bind dma_line_seq dma_line_seq_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .seg_valid_o(seg_valid_o), .seg_ready_i(seg_ready_i),
  .seg_addr_o(seg_addr_o), .seg_write_o(seg_write_o), .seg_len_o(seg_len_o),
  .busy_o(busy_o), .req_ok_o(req_ok_o), .done_o(done_o), .cmpl_bytes(cmpl_bytes)
);

// File: tb/dma_line_seq_bench.sv
`timescale 1ns/1ps
module dma_line_seq_bench;
  localparam int ADDR_W = 32;
  localparam int LINE   = 64;
  localparam int MAXL   = 256;
  localparam int LEN_W  = $clog2(MAXL + 1);
  localparam int IDX_W  = $clog2(MAXL);
  localparam int SEG_W  = $clog2(LINE + 1);
  localparam int DW     = LINE * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0; logic [1:0] req_type = 0;
  logic [ADDR_W-1:0] req_addr = 0; logic [LEN_W-1:0] req_len = 0;
  logic req_ok, req_full, req_unsup, busy, done;
  logic buf_we = 0; logic [IDX_W-1:0] buf_addr = 0; logic [7:0] buf_wdata = 0, buf_rdata;
  logic seg_valid, seg_ready = 0, seg_write;
  logic [ADDR_W-1:0] seg_addr, seg_line;
  logic [SEG_W-1:0] seg_len;
  logic [DW-1:0] seg_data, rsp_data = '0;
  logic rsp_ack = 0, rsp_dvalid = 0, proto_err;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mirror [MAXL];

  always #2 clk = ~clk;

  dma_line_seq u_dma_line_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_type_i(req_type),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_ok_o(req_ok), .req_full_o(req_full),
    .req_unsup_o(req_unsup), .busy_o(busy), .done_o(done), .buf_we_i(buf_we),
    .buf_addr_i(buf_addr), .buf_wdata_i(buf_wdata), .buf_rdata_o(buf_rdata),
    .seg_valid_o(seg_valid), .seg_ready_i(seg_ready), .seg_addr_o(seg_addr),
    .seg_line_o(seg_line), .seg_write_o(seg_write), .seg_len_o(seg_len),
    .seg_data_o(seg_data), .rsp_ack_i(rsp_ack), .rsp_dvalid_i(rsp_dvalid),
    .rsp_data_i(rsp_data), .proto_err_o(proto_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'h5a;
  endfunction

  task automatic fill_buf(int n, int seed);
    for (int i = 0; i < n; i++) begin
      mirror[i] = 8'((i * 13 + seed) & 8'hff);
      buf_we = 1; buf_addr = IDX_W'(i); buf_wdata = mirror[i];
      @(negedge clk);
    end
    buf_we = 0;
  endtask

  // runs one transfer against a model controller; refuse_once probes R2 mid-transfer
  task automatic run_xfer(logic [ADDR_W-1:0] addr, int len, bit wr, int stall, bit refuse_once);
    int cmpl = 0, guard, off, elen, bad;
    bit first = 1;
    req_valid = 1; req_type = wr ? 2'd1 : 2'd0; req_addr = addr; req_len = LEN_W'(len);
    #1 chk("R1 req_ok", 64'(req_ok), 1);
    @(negedge clk); req_valid = 0;
    chk("R1 busy after accept", 64'(busy), 1);
    while (cmpl < len) begin
      guard = 0;
      while (!seg_valid && guard < 50) begin @(negedge clk); guard++; end
      off  = first ? int'(addr % LINE) : 0;
      elen = (len - cmpl < LINE - off) ? len - cmpl : LINE - off;
      chk(first ? "R4 seg addr" : "R5 seg addr", 64'(seg_addr), 64'(addr + ADDR_W'(cmpl)));
      chk(first ? "R4 seg len" : "R5 seg len", 64'(seg_len), 64'(elen));
      chk("R6 line addr", 64'(seg_line), 64'((addr + ADDR_W'(cmpl)) & ~ADDR_W'(LINE - 1)));
      chk("R6 direction", 64'(seg_write), 64'(wr));
      if (wr) begin
        bad = 0;
        for (int j = 0; j < LINE; j++) begin
          logic [7:0] e;
          e = (j >= off && j < off + elen) ? mirror[cmpl + j - off] : 8'h00;
          if (seg_data[j*8 +: 8] !== e) bad++;
        end
        chk("R8 store lanes mismatching", 64'(bad), 0);
      end
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R6 held valid", 64'(seg_valid), 1);
        chk("R6 held addr", 64'(seg_addr), 64'(addr + ADDR_W'(cmpl)));
      end
      seg_ready = 1;
      @(negedge clk); seg_ready = 0;
      chk("R7 no second segment", 64'(seg_valid), 0);
      if (refuse_once) begin
        refuse_once = 0;
        req_valid = 1; req_type = 2'd0; req_addr = 32'h9000; req_len = 4;
        #1 chk("R2 full", 64'(req_full), 1);
        chk("R2 not ok", 64'(req_ok), 0);
        @(negedge clk); req_valid = 0;
        chk("R2 transfer unchanged", 64'(seg_valid), 0);
      end
      if (wr) rsp_ack = 1;
      else begin
        rsp_dvalid = 1;
        for (int j = 0; j < LINE; j++)
          rsp_data[j*8 +: 8] = pat(((addr + ADDR_W'(cmpl)) & ~ADDR_W'(LINE - 1)) + ADDR_W'(j));
      end
      @(negedge clk); rsp_ack = 0; rsp_dvalid = 0;
      cmpl += elen; first = 0;
      if (cmpl == len) begin
        chk("R10 done pulse", 64'(done), 1);
        chk("R10 idle at done", 64'(busy), 0);
        @(negedge clk);
        chk("R10 done one cycle", 64'(done), 0);
      end else begin
        chk("R10 no early done", 64'(done), 0);
      end
    end
    if (!wr) begin
      bad = 0;
      for (int i = 0; i < len; i++) begin
        buf_addr = IDX_W'(i);
        #1 if (buf_rdata !== pat(addr + ADDR_W'(i))) bad++;
      end
      chk("R9 load bytes mismatching", 64'(bad), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset busy", 64'(busy), 0);
    chk("R7 reset seg_valid", 64'(seg_valid), 0);
    chk("R10 reset done", 64'(done), 0);
  endtask

  task automatic t_unsupported;
    req_valid = 1; req_type = 2'd2; req_addr = 32'h40; req_len = 5;
    #1 chk("R3 bad type", 64'(req_unsup), 1);
    chk("R3 bad type not ok", 64'(req_ok), 0);
    req_type = 2'd0; req_len = 0;
    #1 chk("R3 zero len", 64'(req_unsup), 1);
    req_len = LEN_W'(MAXL + 1);
    #1 chk("R3 over max", 64'(req_unsup), 1);
    @(negedge clk); req_valid = 0;
    chk("R3 stays idle", 64'(busy), 0);
    chk("R3 no segment", 64'(seg_valid), 0);
  endtask

  task automatic t_proto;
    rsp_ack = 1;
    #1 chk("R11 ack idle", 64'(proto_err), 1);
    @(negedge clk); rsp_ack = 0;
    chk("R11 idle unaffected", 64'(busy), 0);
    fill_buf(4, 7);
    req_valid = 1; req_type = 2'd1; req_addr = 32'h200; req_len = 4;
    @(negedge clk); req_valid = 0;
    rsp_ack = 1;
    #1 chk("R11 ack before handshake", 64'(proto_err), 1);
    @(negedge clk); rsp_ack = 0;
    chk("R11 segment still offered", 64'(seg_valid), 1);
    seg_ready = 1; @(negedge clk); seg_ready = 0;
    rsp_dvalid = 1;
    #1 chk("R11 data during store", 64'(proto_err), 1);
    @(negedge clk); rsp_dvalid = 0;
    chk("R11 store still waiting", 64'(busy), 1);
    chk("R11 no done", 64'(done), 0);
    rsp_ack = 1;
    #1 chk("R11 good ack no err", 64'(proto_err), 0);
    @(negedge clk); rsp_ack = 0;
    chk("R10 done after ack", 64'(done), 1);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    fill_buf(10, 1);
    run_xfer(32'h3c, 10, 1'b1, 2, 1'b1);   // store crossing one line
    run_xfer(32'h105, 130, 1'b0, 0, 1'b0); // load over three segments
    run_xfer(32'h210, 3, 1'b0, 1, 1'b0);   // load within one line
    fill_buf(MAXL, 3);
    run_xfer(32'h400, MAXL, 1'b1, 0, 1'b0); // aligned store at max length
    run_xfer(32'h7f, 65, 1'b0, 0, 1'b1);   // one-byte head segment
    t_unsupported();
    t_proto();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule